// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It decides whether an embedded program or erase has finished by reading the status byte again and again and watching bit 6, which flips on every read while the device is busy. A one-cycle `go` pulse starts a poll. The block then issues read cycles on a request/acknowledge port: it holds an active-low output-enable strobe low until the memory side acknowledges, and captures the returned byte on that edge.

In completion mode the block compares bit 6 across a pair of reads. If bit 6 is steady, it reports pass. If bit 6 changed and bit 5 of the later read is high, it runs one recheck pair, because toggling may have stopped just as bit 5 rose. If bit 6 changed and bit 5 is low, it polls again, up to a limit on the number of pairs.

In classify mode the block runs a single read pair at the given sector address. It reports whether the device is actively erasing or whether that sector is erase-suspended.

Top module: `toggle_poller`

## Requirements
- R1: After reset, `busy`, `done_pass`, `done_fail` and `cls_valid` are low and `rd_oe_n` is high, and `rd_oe_n` stays high whenever `busy` is low.
- R2: A `go` pulse while idle raises `busy` on the next cycle, latches `classify` and `sec_addr`, and starts a read. A `go` pulse while `busy` is high has no effect on the running poll.
- R3: Each read holds `rd_oe_n` low until the cycle in which `rd_ack` is high, and the byte on `rd_data` is captured in that cycle. `rd_addr` carries the latched address and stays constant for the whole poll.
- R4: In completion mode, if bit 6 is equal in the two reads of a pair, `done_pass` pulses after that pair. A poll that is already finished therefore ends after exactly two reads.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 0, another pair of reads follows.
- R6: If bit 6 differs and bit 5 of the second read is 1, one recheck pair follows. If bit 6 is equal in the recheck pair, `done_pass` pulses.
- R7: If bit 6 still differs in the recheck pair, `done_fail` pulses.
- R8: If bit 6 differs with bit 5 low in `MAX_PAIRS` consecutive pairs, `done_fail` pulses after that last pair. A steady pair that comes as pair `MAX_PAIRS` still passes.
- R9: `done_pass` and `done_fail` are single-cycle pulses. They are never high together, `busy` is high during the pulse, and `busy` is low on the following cycle.
- R10: In classify mode, exactly one pair is read. `cls_valid` pulses together with `done_pass`, and `cls_code` is computed from that pair:
  - 2'b01 (erasing) if bit 6 differs;
  - 2'b10 (suspended) if bit 6 is equal and bit 2 differs;
  - otherwise 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse |
| classify | input | 1 | 1 selects sector classification, 0 selects completion polling |
| sec_addr | input | AW | Address that the reads are issued to |
| rd_oe_n | output | 1 | Active-low output-enable strobe, low while a read is pending |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | 8 | Status byte returned by the read |
| busy | output | 1 | High from start until the done pulse |
| done_pass | output | 1 | Operation complete |
| done_fail | output | 1 | Operation failed or poll limit reached |
| cls_valid | output | 1 | Classification result valid |
| cls_code | output | 2 | Sector state: 01 erasing, 10 suspended, 00 neither |

## Verification
The bound checker checks the following on every cycle:
- the strobe is idle when the block is not busy, and is held low until the acknowledge arrives;
- the address is stable during a poll;
- `go` starts a poll when the block is idle;
- the done pulses are exclusive and are followed by `busy` dropping;
- a classification result always comes with a pass.

Only the bench's scripted status sequences can show that the decision is correct: the number of reads taken, the bit 5 recheck path, the poll limit at its exact boundary, the classification codes, and that a second `go` during a poll is ignored.

// File: rtl/toggle_poller.sv
module toggle_poller #(
  parameter int AW        = 20,
  parameter int MAX_PAIRS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          classify,
  input  logic [AW-1:0] sec_addr,
  output logic          rd_oe_n,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done_pass,
  output logic          done_fail,
  output logic          cls_valid,
  output logic [1:0]    cls_code
);
  localparam int CW = $clog2(MAX_PAIRS) + 1;

  typedef enum logic [1:0] {IDLE, RDA, RDB, EVAL} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic          cls_q, recheck;
  logic [CW-1:0] pairs;
  logic          a6, a2, b6, b5, b2;

  wire tog6      = a6 ^ b6;
  wire tog2      = a2 ^ b2;
  wire last_pair = (pairs == CW'(MAX_PAIRS - 1));
  wire in_eval   = (st == EVAL);

  assign busy      = (st != IDLE);
  assign rd_oe_n   = !((st == RDA) || (st == RDB));
  assign rd_addr   = addr_q;
  assign done_pass = in_eval && (cls_q || !tog6);
  assign done_fail = in_eval && !cls_q && tog6 && (recheck || (!b5 && last_pair));
  assign cls_valid = in_eval && cls_q;
  assign cls_code  = tog6 ? 2'b01 : (tog2 ? 2'b10 : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      addr_q  <= '0;
      cls_q   <= 1'b0;
      recheck <= 1'b0;
      pairs   <= '0;
      a6 <= 1'b0; a2 <= 1'b0;
      b6 <= 1'b0; b5 <= 1'b0; b2 <= 1'b0;
    end else begin
      case (st)
        IDLE: if (go) begin
          addr_q  <= sec_addr;
          cls_q   <= classify;
          recheck <= 1'b0;
          pairs   <= '0;
          st      <= RDA;
        end
        RDA: if (rd_ack) begin
          a6 <= rd_data[6];
          a2 <= rd_data[2];
          st <= RDB;
        end
        RDB: if (rd_ack) begin
          b6 <= rd_data[6];
          b5 <= rd_data[5];
          b2 <= rd_data[2];
          st <= EVAL;
        end
        default: begin
          if (done_pass || done_fail) st <= IDLE;
          else begin
            st <= RDA;
            if (b5) recheck <= 1'b1;
            else    pairs   <= pairs + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module toggle_poller_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          rd_oe_n,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          busy,
  input logic          done_pass,
  input logic          done_fail,
  input logic          cls_valid
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_oe_n);
  assert_go_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> (busy && !rd_oe_n));
  assert_strobe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_oe_n && !rd_ack) |=> !rd_oe_n);
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(rd_addr)));
  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pass && done_fail));
  assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pass || done_fail) |-> busy);
  assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pass || done_fail) |=> (!busy && !done_pass && !done_fail));
  assert_cls_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> done_pass);
endmodule

bind toggle_poller toggle_poller_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .rd_oe_n(rd_oe_n), .rd_addr(rd_addr),
  .rd_ack(rd_ack), .busy(busy), .done_pass(done_pass), .done_fail(done_fail),
  .cls_valid(cls_valid)
);

// File: tb/sim_toggle_poller.sv
`timescale 1ns/1ps
module sim_toggle_poller;
  localparam int AW = 20;
  localparam int MP = 4;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, classify = 1'b0;
  logic [AW-1:0] sec_addr = '0;
  logic rd_oe_n, rd_ack = 1'b0, busy, done_pass, done_fail, cls_valid;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [1:0] cls_code;

  always #4 clk = ~clk;

  toggle_poller #(.AW(AW), .MAX_PAIRS(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .classify(classify), .sec_addr(sec_addr),
    .rd_oe_n(rd_oe_n), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done_pass(done_pass), .done_fail(done_fail),
    .cls_valid(cls_valid), .cls_code(cls_code));

  int errors = 0, checks = 0, cycles = 0, nreads = 0, wait_cnt = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [7:0] rsp_q[$];
  int exp_kind[$], exp_reads[$], exp_cls[$], exp_code[$];
  logic end_pending = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_ack) rd_ack <= 1'b0;
    else if (rst_n && !rd_oe_n) begin
      if (wait_cnt >= nreads % 3) begin
        chk("R3 read address", int'(rd_addr), int'(cur_addr));
        rd_data <= (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'h00;
        rd_ack  <= 1'b1;
        nreads++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (end_pending) begin
      chk("R9 busy low after done", int'(busy), 0);
      chk("R9 single-cycle done", int'(done_pass | done_fail), 0);
      end_pending = 1'b0;
    end
    if (rst_n && (done_pass || done_fail)) begin
      if (exp_kind.size() == 0) chk("R9 unexpected done", 1, 0);
      else begin
        int k, r, c, cd;
        k = exp_kind.pop_front(); r = exp_reads.pop_front();
        c = exp_cls.pop_front(); cd = exp_code.pop_front();
        chk("R4-result kind (1=fail) R7 R8", int'(done_fail), k);
        chk("R5 R6 read count", nreads, r);
        chk("R9 busy during done", int'(busy), 1);
        chk("R10 cls_valid", int'(cls_valid), c);
        if (c != 0) chk("R10 cls_code", int'(cls_code), cd);
      end
      end_pending = 1'b1;
    end
  end

  task automatic run(input logic cls, input logic [AW-1:0] a, input int kind,
                     input int reads, input int code, input logic extra_go);
    exp_kind.push_back(kind); exp_reads.push_back(reads);
    exp_cls.push_back(int'(cls)); exp_code.push_back(code);
    nreads = 0; cur_addr = a;
    @(negedge clk); go = 1'b1; classify = cls; sec_addr = a;
    @(negedge clk); go = 1'b0; sec_addr = ~a;
    chk("R2 busy after go", int'(busy), 1);
    if (extra_go) begin
      @(negedge clk); go = 1'b1; classify = ~cls;
      @(negedge clk); go = 1'b0;
    end
    for (int i = 0; i < 500 && exp_kind.size() != 0; i++) @(negedge clk);
    chk("R2 outcome consumed", exp_kind.size(), 0);
    chk("R3 all bytes read", rsp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 strobe idle", int'(rd_oe_n), 1);
    chk("R1 no done", int'(done_pass | done_fail | cls_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(busy), 0);

    rsp_q = '{8'h00, 8'h00};
    run(1'b0, 20'h12345, 0, 2, 0, 1'b0);                              // R4
    rsp_q = '{8'h40, 8'h00, 8'hFF, 8'hFF};
    run(1'b0, 20'h0ABCD, 0, 4, 0, 1'b1);                              // R5, R2 ignored go
    rsp_q = '{8'h40, 8'h20, 8'h00, 8'h00};
    run(1'b0, 20'h00011, 0, 4, 0, 1'b0);                              // R6
    rsp_q = '{8'h40, 8'h20, 8'h60, 8'h20};
    run(1'b0, 20'hF0000, 1, 4, 0, 1'b0);                              // R7
    rsp_q = '{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00};
    run(1'b0, 20'h55555, 1, 8, 0, 1'b0);                              // R8 limit
    rsp_q = '{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h44, 8'h40};
    run(1'b0, 20'h55556, 0, 8, 0, 1'b0);                              // R8 boundary pass
    rsp_q = '{8'h40, 8'h04};
    run(1'b1, 20'h00100, 0, 2, 1, 1'b0);                              // R10 erasing
    rsp_q = '{8'h04, 8'h00};
    run(1'b1, 20'h00200, 0, 2, 2, 1'b0);                              // R10 suspended
    rsp_q = '{8'h24, 8'h24};
    run(1'b1, 20'h00300, 0, 2, 0, 1'b1);                              // R10 neither

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule